// File: doc/BRIEF.md
# Interlaced Raster Position and Sync Status

This block keeps the raster position of a video timing generator: the dot position inside the current line, the current line number and an odd/even field flag. Each cycle with `dot_en` high moves the raster forward by one dot. At the end of a line the line counter advances. At the end of a frame the line counter returns to zero, and when interlace is enabled the field flag flips. A one-cycle `frame_done_o` pulse marks the point where the raster first reaches the fixed retrace-end line (42).

Software or a control unit programs the timing through one write port. A 3-bit select code picks the target value:

| Code | Target |
|------|--------|
| 0 | Frame size |
| 1 | Sync configuration |
| 2 | Sync widths |
| 3 | Front porch |
| 4 | Back porch |

The block always shows a packed 14-bit status word. That word is decoded from the current position, the line parity compared with the field flag, and the programmed sync and porch widths. A line whose parity matches the field flag reports its phases in a different way from a line whose parity does not match.

The dot counter uses a step classifier with four named outcomes:

| Step | Effect |
|------|--------|
| STEP_IDLE | No change. Used when there is no enable, or when the dots field is zero. |
| STEP_DOT | The dot position advances inside the line. |
| STEP_LINE | The dot position returns to 0 and the line advances. |
| STEP_WRAP | The dot position and the line both return to 0, and the field flips if interlace is enabled. |

The status decoder puts each line into one of three classes:

| Class | Condition |
|-------|-----------|
| CLS_NEAR | Line parity equals the field flag. |
| CLS_FAR_TOP | Parity differs and the line is below the vertical sync count. |
| CLS_FAR_BODY | Parity differs and the line is at or above the vertical sync count. |

Top module: `raster_timing`

## Requirements
- R1: After reset the line, dot position and field flag are 0 and `frame_done_o` is low. The frame size is 625 lines of 864 dots. The horizontal sync width is 128 dots, the vertical sync count is 5 lines, the front porch is 1 dot and the back porch is 108 dots.
- R2: A write with select 0 takes lines-per-frame minus one from data bits 25:16 and dots-per-line minus one from bits 9:0. Each field is 10 bits and all other bits are dropped. Selects 5 to 7 change nothing.
- R3: Each cycle with `dot_en` high advances the raster by exactly one dot. With `dot_en` low the line, field and status hold and `frame_done_o` stays low.
- R4: After the last dot of a line the next line starts at dot 0. After the last line the line number returns to 0. At that return the field flag toggles only if sync configuration (select 1) bit 4 is set.
- R5: `frame_done_o` is high for exactly one cycle, in the cycle where `line_o` first shows line 42 after being below it, or first shows a line at or above 42 after passing through a wrap.
- R6: While the dots-per-line field holds 0, dot enables have no effect on the line, the field or the status.
- R7: Status bits 9:0 hold the current line and bit 10 holds the field flag (1 = odd).
- R8: When line bit 0 equals the field flag, bit 12 (hsync off) is set when the dot position exceeds the hsync width. If the line is at or above the vsync count, bit 13 (vsync off) is also set, and bit 11 (display active) is set when the position exceeds the front porch.
- R9: When line bit 0 differs from the field flag, bit 12 is always set. At or above the vsync count, bit 13 is also set, and bit 11 is set while the position plus the back porch is below the line length.
- R10: The hsync width is (select-2 bits 6:0 plus 1) times 2 dots. The vsync count is select-2 bits 11:8. The front porch is select-3 bits 9:0 plus 1 dot. The back porch is select-4 bits 9:0, in dots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dot_en | input | 1 | Advance the raster by one dot |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 3 | Configuration target select |
| cfg_wr_data | input | 32 | Configuration write data |
| line_o | output | 10 | Current line |
| odd_field_o | output | 1 | Field flag, 1 = odd |
| frame_done_o | output | 1 | One-cycle pulse on reaching the retrace-end line |
| status_o | output | 14 | Packed sync status word |

## Verification
A wrong dot position inside a line shows up at once in the status word: hsync-off, active and porch bits flip at the wrong dot, within the same line. A wrong line counter or a missed wrap shows up in `line_o` within one line time. It also shifts `frame_done_o` away from line 42. A wrong field flag or parity decode swaps the near and far status behaviour on every line of the field, so it appears within two lines. The checks compare every status bit after every dot against an independent position model, across non-interlaced frames, interlaced frames, gapped enables and a held zero-length line.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int RT_LINE_W = 10;
    localparam int RT_DATA_W = 32;
    localparam int RT_SEL_W  = 3;
    localparam int RT_STAT_W = 14;

    typedef enum logic [RT_SEL_W-1:0] {
        SEL_FRAME_SIZE = 3'd0,
        SEL_SYNC_CFG   = 3'd1,
        SEL_SYNC_WIDTH = 3'd2,
        SEL_FRONT      = 3'd3,
        SEL_BACK       = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic [RT_LINE_W-1:0] lines_m1;
        logic [RT_LINE_W-1:0] dots_m1;
        logic                 interlace;
        logic [6:0]           hs_half_m1;
        logic [3:0]           vs_lines;
        logic [RT_LINE_W-1:0] front_m1;
        logic [RT_LINE_W-1:0] back_dots;
    } raster_cfg_t;

    typedef enum logic [1:0] {
        STEP_IDLE,
        STEP_DOT,
        STEP_LINE,
        STEP_WRAP
    } scan_step_e;

    typedef enum logic [1:0] {
        CLS_NEAR,
        CLS_FAR_TOP,
        CLS_FAR_BODY
    } line_class_e;

endpackage

// File: rtl/raster_cfg_regs.sv
module raster_cfg_regs
    import raster_pkg::*;
#(
    parameter logic [RT_LINE_W-1:0] BP_DEFAULT = 10'd108
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RT_SEL_W-1:0]  wr_sel,
    input  logic [RT_DATA_W-1:0] wr_data,
    output raster_cfg_t          cfg_o
);

    localparam int HI_LSB = 16;

    raster_cfg_t cfg_q;
    raster_cfg_t cfg_d;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[RT_DATA_W-1:HI_LSB+RT_LINE_W],
                              wr_data[HI_LSB-1:RT_LINE_W]};

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_FRAME_SIZE: begin
                    cfg_d.lines_m1 = wr_data[HI_LSB +: RT_LINE_W];
                    cfg_d.dots_m1  = wr_data[RT_LINE_W-1:0];
                end
                SEL_SYNC_CFG:   cfg_d.interlace = wr_data[4];
                SEL_SYNC_WIDTH: begin
                    cfg_d.hs_half_m1 = wr_data[6:0];
                    cfg_d.vs_lines   = wr_data[11:8];
                end
                SEL_FRONT:      cfg_d.front_m1  = wr_data[RT_LINE_W-1:0];
                SEL_BACK:       cfg_d.back_dots = wr_data[RT_LINE_W-1:0];
                default:        cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.lines_m1   <= 10'h270;
            cfg_q.dots_m1    <= 10'h35F;
            cfg_q.interlace  <= 1'b0;
            cfg_q.hs_half_m1 <= 7'h3F;
            cfg_q.vs_lines   <= 4'd5;
            cfg_q.front_m1   <= '0;
            cfg_q.back_dots  <= BP_DEFAULT;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/raster_scan_ctr.sv
module raster_scan_ctr
    import raster_pkg::*;
#(
    parameter int RETRACE_END = 42
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dot_en,
    input  logic [RT_LINE_W-1:0] dots_m1,
    input  logic [RT_LINE_W-1:0] lines_m1,
    input  logic                 interlace,
    output logic [RT_LINE_W-1:0] pos_o,
    output logic [RT_LINE_W-1:0] line_o,
    output logic                 field_o,
    output logic                 frame_done_o
);

    localparam logic [RT_LINE_W-1:0] RE_LINE = RT_LINE_W'(RETRACE_END);

    scan_step_e           step;
    logic [RT_LINE_W-1:0] pos_q,  pos_d;
    logic [RT_LINE_W-1:0] line_q, line_d;
    logic                 field_q, field_d;
    logic                 frame_q, frame_d;

    // Step classifier: what one enabled dot does to the raster.
    always_comb begin
        if (!dot_en || dots_m1 == '0) begin
            step = STEP_IDLE;
        end else if (pos_q < dots_m1) begin
            step = STEP_DOT;
        end else if (line_q < lines_m1) begin
            step = STEP_LINE;
        end else begin
            step = STEP_WRAP;
        end
    end

    always_comb begin
        pos_d   = pos_q;
        line_d  = line_q;
        field_d = field_q;
        unique case (step)
            STEP_IDLE: ;
            STEP_DOT:  pos_d = pos_q + 1'b1;
            STEP_LINE: begin
                pos_d  = '0;
                line_d = line_q + 1'b1;
            end
            STEP_WRAP: begin
                pos_d   = '0;
                line_d  = '0;
                field_d = field_q ^ interlace;
            end
            default: ;
        endcase
        frame_d = (step == STEP_LINE || step == STEP_WRAP) &&
                  (line_d >= RE_LINE) &&
                  ((line_q < RE_LINE) || (line_d < line_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q   <= '0;
            line_q  <= '0;
            field_q <= 1'b0;
            frame_q <= 1'b0;
        end else begin
            pos_q   <= pos_d;
            line_q  <= line_d;
            field_q <= field_d;
            frame_q <= frame_d;
        end
    end

    assign pos_o        = pos_q;
    assign line_o       = line_q;
    assign field_o      = field_q;
    assign frame_done_o = frame_q;

endmodule

// File: rtl/raster_sync_status.sv
module raster_sync_status
    import raster_pkg::*;
(
    input  logic [RT_LINE_W-1:0] pos,
    input  logic [RT_LINE_W-1:0] line,
    input  logic                 field,
    input  logic [RT_LINE_W-1:0] dots_m1,
    input  logic [6:0]           hs_half_m1,
    input  logic [3:0]           vs_lines,
    input  logic [RT_LINE_W-1:0] front_m1,
    input  logic [RT_LINE_W-1:0] back_dots,
    output logic [RT_STAT_W-1:0] status_o
);

    localparam int CW = RT_LINE_W + 2;

    line_class_e    cls;
    logic [CW-1:0]  pos_x, hs_w, fp_w, tail_x, len_x;
    logic           past_vs, hs_off, vs_off, active;

    assign pos_x   = CW'(pos);
    assign hs_w    = (CW'(hs_half_m1) + 1'b1) << 1;
    assign fp_w    = CW'(front_m1) + 1'b1;
    assign tail_x  = CW'(pos) + CW'(back_dots);
    assign len_x   = CW'(dots_m1) + 1'b1;
    assign past_vs = line >= RT_LINE_W'(vs_lines);

    always_comb begin
        if (line[0] == field) begin
            cls = CLS_NEAR;
        end else if (!past_vs) begin
            cls = CLS_FAR_TOP;
        end else begin
            cls = CLS_FAR_BODY;
        end
    end

    always_comb begin
        hs_off = 1'b0;
        vs_off = 1'b0;
        active = 1'b0;
        unique case (cls)
            CLS_NEAR: begin
                hs_off = pos_x > hs_w;
                vs_off = past_vs;
                active = past_vs && (pos_x > fp_w);
            end
            CLS_FAR_TOP: hs_off = 1'b1;
            CLS_FAR_BODY: begin
                hs_off = 1'b1;
                vs_off = 1'b1;
                active = tail_x < len_x;
            end
            default: ;
        endcase
        status_o = {vs_off, hs_off, active, field, line};
    end

endmodule

// File: rtl/raster_timing.sv
module raster_timing
    import raster_pkg::*;
#(
    parameter int                   RETRACE_END = 42,
    parameter logic [RT_LINE_W-1:0] BP_DEFAULT  = 10'd108
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dot_en,
    input  logic                 cfg_wr_en,
    input  logic [RT_SEL_W-1:0]  cfg_wr_sel,
    input  logic [RT_DATA_W-1:0] cfg_wr_data,
    output logic [RT_LINE_W-1:0] line_o,
    output logic                 odd_field_o,
    output logic                 frame_done_o,
    output logic [RT_STAT_W-1:0] status_o
);

    raster_cfg_t          cfg_q;
    logic [RT_LINE_W-1:0] pos;

    raster_cfg_regs #(.BP_DEFAULT(BP_DEFAULT)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .cfg_o   (cfg_q)
    );

    raster_scan_ctr #(.RETRACE_END(RETRACE_END)) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .dot_en       (dot_en),
        .dots_m1      (cfg_q.dots_m1),
        .lines_m1     (cfg_q.lines_m1),
        .interlace    (cfg_q.interlace),
        .pos_o        (pos),
        .line_o       (line_o),
        .field_o      (odd_field_o),
        .frame_done_o (frame_done_o)
    );

    raster_sync_status u_stat (
        .pos        (pos),
        .line       (line_o),
        .field      (odd_field_o),
        .dots_m1    (cfg_q.dots_m1),
        .hs_half_m1 (cfg_q.hs_half_m1),
        .vs_lines   (cfg_q.vs_lines),
        .front_m1   (cfg_q.front_m1),
        .back_dots  (cfg_q.back_dots),
        .status_o   (status_o)
    );

endmodule

// File: rtl/raster_timing_checker.sv
module raster_timing_checker
    import raster_pkg::*;
#(
    parameter int RETRACE_END = 42
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dot_en,
    input logic [RT_LINE_W-1:0] line_o,
    input logic                 odd_field_o,
    input logic                 frame_done_o,
    input logic [RT_STAT_W-1:0] status_o,
    input logic [RT_LINE_W-1:0] dots_m1,
    input logic                 interlace
);

    a_r3_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_en |=> ($stable(line_o) && $stable(odd_field_o) && !frame_done_o));

    a_r6_hold_zero_length: assert property (@(posedge clk) disable iff (!rst_n)
        (dots_m1 == '0) |=> ($stable(line_o) && $stable(odd_field_o) && !frame_done_o));

    a_r5_pulse_at_retrace_end: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> (line_o == RT_LINE_W'(RETRACE_END)));

    a_r5_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    a_r4_field_flips_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (odd_field_o != $past(odd_field_o)) |-> (line_o == '0 && $past(interlace)));

    a_r4_line_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> (line_o == '0 || line_o == RT_LINE_W'($past(line_o) + 1'b1)));

    a_r7_status_position_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[RT_LINE_W-1:0] == line_o) && (status_o[10] == odd_field_o));

    a_r8_active_needs_vsync_off: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[11] |-> status_o[13]);

    a_r9_far_line_hsync_off: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o[0] != odd_field_o) |-> status_o[12]);

endmodule

bind raster_timing raster_timing_checker #(.RETRACE_END(RETRACE_END)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dot_en       (dot_en),
    .line_o       (line_o),
    .odd_field_o  (odd_field_o),
    .frame_done_o (frame_done_o),
    .status_o     (status_o),
    .dots_m1      (cfg_q.dots_m1),
    .interlace    (cfg_q.interlace)
);

// File: tb/raster_timing_bench.sv
module raster_timing_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dot_en = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [9:0]  line_o;
    logic        odd_field_o;
    logic        frame_done_o;
    logic [13:0] status_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model of the raster and configuration
    int m_pos, m_line, m_field, m_frame;
    int m_dots_m1, m_lines_m1, m_il, m_hs, m_vs, m_fp, m_bp;
    int toggles;

    always #10 clk = ~clk;

    raster_timing u_raster_timing (
        .clk          (clk),
        .rst_n        (rst_n),
        .dot_en       (dot_en),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_sel   (cfg_wr_sel),
        .cfg_wr_data  (cfg_wr_data),
        .line_o       (line_o),
        .odd_field_o  (odd_field_o),
        .frame_done_o (frame_done_o),
        .status_o     (status_o)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_status();
        int s, act, hs, vs;
        act = 0; hs = 0; vs = 0;
        if ((m_line % 2) == m_field) begin
            hs = (m_pos > (m_hs + 1) * 2) ? 1 : 0;
            if (m_line >= m_vs) begin
                vs = 1;
                act = (m_pos > m_fp + 1) ? 1 : 0;
            end
        end else begin
            hs = 1;
            if (m_line >= m_vs) begin
                vs = 1;
                act = (m_pos + m_bp < m_dots_m1 + 1) ? 1 : 0;
            end
        end
        s = m_line | (m_field << 10) | (act << 11) | (hs << 12) | (vs << 13);
        return s;
    endfunction

    task automatic check_all(input string tag);
        string stag;
        stag = ((m_line % 2) == m_field) ? "R8 status near" : "R9 status far";
        check_eq({tag, " R4 line"}, int'(line_o), m_line);
        check_eq({tag, " R4 field"}, int'(odd_field_o), m_field);
        check_eq({tag, " R5 frame_done"}, int'(frame_done_o), m_frame);
        check_eq({tag, " ", stag}, int'(status_o), exp_status());
    endtask

    task automatic model_step();
        m_frame = 0;
        if (m_dots_m1 == 0) return;
        if (m_pos < m_dots_m1) begin
            m_pos++;
        end else if (m_line < m_lines_m1) begin
            m_pos = 0;
            m_line++;
            if (m_line == 42) m_frame = 1;
        end else begin
            m_pos = 0;
            m_line = 0;
            if (m_il != 0) begin
                m_field ^= 1;
                toggles++;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        dot_en = 1'b0;
        cfg_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_pos = 0; m_line = 0; m_field = 0; m_frame = 0;
        m_dots_m1 = 863; m_lines_m1 = 624; m_il = 0;
        m_hs = 63; m_vs = 5; m_fp = 0; m_bp = 108;
        @(negedge clk);
    endtask

    task automatic cfg_write(input int sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_sel = 3'(sel);
        cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        case (sel)
            0: begin
                m_lines_m1 = int'(data[25:16]);
                m_dots_m1  = int'(data[9:0]);
            end
            1: m_il = int'(data[4]);
            2: begin
                m_hs = int'(data[6:0]);
                m_vs = int'(data[11:8]);
            end
            3: m_fp = int'(data[9:0]);
            4: m_bp = int'(data[9:0]);
            default: ;
        endcase
    endtask

    // gap = idle cycles after each dot, checked for no change (R3)
    task automatic run_dots(input int n, input int gap, input string tag);
        for (int i = 0; i < n; i++) begin
            dot_en = 1'b1;
            @(negedge clk);
            model_step();
            check_all(tag);
            if (gap > 0) begin
                dot_en = 1'b0;
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    m_frame = 0;
                    check_all({tag, " R3 gap"});
                end
            end
        end
        dot_en = 1'b0;
        @(negedge clk);
        m_frame = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check_eq("R1 reset line", int'(line_o), 0);
        check_eq("R1 reset field", int'(odd_field_o), 0);
        check_eq("R1 reset frame_done", int'(frame_done_o), 0);
        check_eq("R1 R7 reset status", int'(status_o), 0);
    endtask

    task automatic t_default_line();
        do_reset();
        run_dots(864, 0, "R1 default");
        check_eq("R1 default line length", int'(line_o), 1);
        check_eq("R1 R9 default status", int'(status_o), 14'h1001);
    endtask

    task automatic t_programmed();
        do_reset();
        cfg_write(0, 32'hFC31_FC0F);
        cfg_write(2, 32'hABCD_F382);
        cfg_write(3, 32'hFFFF_FC03);
        cfg_write(4, 32'h0000_0005);
        cfg_write(7, 32'hFFFF_FFFF);
        check_eq("R2 ignored select keeps line", int'(line_o), 0);
        check_eq("R2 ignored select keeps status", int'(status_o), 0);
        run_dots(103, 0, "R10 program");
        check_eq("R10 near line 6 dot 7", int'(status_o), 14'h3806);
        run_dots(20, 0, "R10 program");
        check_eq("R9 far line 7 dot 11", int'(status_o), 14'h3007);
        run_dots(200, 1, "R3 gapped");
        run_dots(1600, 0, "R4 frames");
    endtask

    task automatic t_interlace();
        toggles = 0;
        cfg_write(1, 32'hFFFF_FF10);
        run_dots(1700, 0, "R4 interlace");
        check_eq("R4 interlace toggles seen", int'(toggles >= 2), 1);
    endtask

    task automatic t_zero_length();
        int held_line, held_status;
        cfg_write(0, 32'h0031_0000);
        held_line = int'(line_o);
        held_status = int'(status_o);
        run_dots(10, 0, "R6 zero length");
        check_eq("R6 line held", int'(line_o), held_line);
        check_eq("R6 status held", int'(status_o), held_status);
        cfg_write(0, 32'h0031_000F);
        run_dots(40, 0, "R6 restored");
    endtask

    initial begin
        t_reset();
        t_default_line();
        t_programmed();
        t_interlace();
        t_zero_length();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule